// File: doc/BRIEF.md
# Configuration Image Bit-Order Normaliser and Page Packer

This block sits in the byte path between an image source and a page programmer. For every image it decides whether the bits inside each byte must be mirrored before storage. It then forwards the whole image in fixed-size pages and completes a short final page with filler bytes. The decision depends on a fixed leading signature. When the image opens with that exact signature, the bytes already have the storage bit order and go through untouched. In every other case each byte is mirrored.

The first page of each image is held inside the block until the decision can be made. That is the point where a full page has arrived, or where the image ends earlier. The held bytes are then released in arrival order, and the rest of the image streams through a single output register. Both byte streams use valid/ready. A beat moves on a rising clock edge where valid and ready are both high. The source must keep a byte and its markers steady while its valid is high and ready is low. The block holds its own output byte and flags steady while out_valid is high and out_ready is low. While the first page is being collected, input ready stays high. While held bytes or filler bytes are being sent, input ready is low. During pass-through, input ready follows the availability of the output register.

Top module: `cfg_bitorder_pager`

## Requirements
- R1: The signature is sixteen bytes of 0xFF followed by 0x55, 0x99, 0xAA, 0x66, compared against image bytes 0 to 19. If all twenty match, in_base_zero was high on the first beat, and the image holds at least 32 bytes, every image byte is output unchanged.
- R2: If any one of the twenty signature bytes differs, every byte of the image is output with its bits mirrored: output bit i equals input bit 7-i.
- R3: An image shorter than 32 bytes is always mirrored, even when it carries the signature.
- R4: An image whose first beat has in_base_zero low is always mirrored, even when it carries the signature and is long enough.
- R5: Output is grouped into 32-byte pages. out_page_end is high on byte 31 of every page. out_img_end is high only on the final byte of the final page of an image.
- R6: A final page that the image does not fill is completed with 0xFF bytes, which are never mirrored.
- R7: No byte of an image is output before its first 32 bytes have arrived or it has ended. Output keeps the input byte order.
- R8: While out_valid is high and out_ready is low, out_data, out_page_end and out_img_end hold their values. No accepted input byte is lost or duplicated.
- R9: Input beats that arrive between images without in_sof are consumed and produce no output.
- R10: The mirror decision is latched when the first page closes and holds until the image ends. Each new image is judged on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input image byte |
| in_sof | input | 1 | Marks the first byte of an image |
| in_eof | input | 1 | Marks the last byte of an image |
| in_base_zero | input | 1 | Image is placed at storage offset 0; sampled with the first byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output byte, mirrored or unchanged, or filler |
| out_page_end | output | 1 | Output byte is the last of a page |
| out_img_end | output | 1 | Output byte is the last of the image |

## Verification
The bench uses the default values: 32-byte pages, a 16-byte run of 0xFF, and the 0x5599AA66 sync word, so the prefix buffer is exactly one page deep. With these values, a short sequence of images reaches every corner of the decision: an exact single page with no filler, lengths of 1, 25, 33, 40, 50 and 70 bytes, a single corrupted signature byte at the front or near the end, and a cleared base flag. Stray beats between images are also covered. Random gaps on the input and random back-pressure on the output exercise the hold-and-release path in every phase.

// File: rtl/cfgbo_pkg.sv
package cfgbo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_DRAIN,
    ST_FLOW,
    ST_PAD
  } phase_e;

  // Expected signature byte at position idx: a run of 0xFF, then the sync
  // word sent most significant byte first.
  function automatic logic [7:0] hdr_ref_byte(input int idx, input int fill,
                                              input logic [31:0] sync);
    int k;
    if (idx < fill) return 8'hFF;
    k = idx - fill;
    if (k > 3) k = 3;
    return sync[8*(3-k) +: 8];
  endfunction

endpackage

// File: rtl/cfgbo_hdr_match.sv
module cfgbo_hdr_match import cfgbo_pkg::*; #(
  parameter int          HDR_FILL  = 16,
  parameter logic [31:0] SYNC_WORD = 32'h5599_AA66,
  parameter int          IDXW      = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            first,
  input  logic [IDXW-1:0] idx,
  input  logic [7:0]      data,
  output logic            hit_next
);
  localparam int HDR_LEN = HDR_FILL + 4;

  logic hit_q;
  logic byte_ok;

  always_comb begin
    byte_ok  = (int'(idx) >= HDR_LEN) ||
               (data == hdr_ref_byte(int'(idx), HDR_FILL, SYNC_WORD));
    hit_next = (first ? 1'b1 : hit_q) && byte_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hit_q <= 1'b0;
    else if (step) hit_q <= hit_next;
  end

  // once one signature byte has missed, later bytes of the image cannot restore the hit
  p_miss_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !first && !hit_q) |=> !hit_q);

endmodule

// File: rtl/cfgbo_prefix_buf.sv
module cfgbo_prefix_buf #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/cfgbo_lane_xform.sv
module cfgbo_lane_xform #(
  parameter int W = 8
) (
  input  logic         rev,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] out_b
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    assign out_b[i] = rev ? in_b[W-1-i] : in_b[i];
  end

endmodule

// File: rtl/cfg_bitorder_pager.sv
module cfg_bitorder_pager import cfgbo_pkg::*; #(
  parameter int          PAGE_BYTES = 32,
  parameter int          HDR_FILL   = 16,
  parameter logic [31:0] SYNC_WORD  = 32'h5599_AA66
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       in_base_zero,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_page_end,
  output logic       out_img_end
);
  localparam int IDXW = $clog2(PAGE_BYTES);
  localparam int CNTW = IDXW + 1;
  localparam logic [CNTW-1:0] LAST_IDX = CNTW'(PAGE_BYTES - 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(PAGE_BYTES);
  localparam logic [IDXW-1:0] POS_LAST = IDXW'(PAGE_BYTES - 1);

  phase_e          phase_q, phase_d;
  logic [CNTW-1:0] cnt_q, rd_q;
  logic [IDXW-1:0] pos_q;
  logic            rev_q, eof_q, base_q;
  logic            out_valid_q, pe_q, ie_q;
  logic [7:0]      out_data_q;

  logic            slot_free, in_fire, fill_beat, fill_last, base_eff;
  logic            hit_next, keep_order, drain_last;
  logic [CNTW-1:0] fill_idx;
  logic            emit, img_end, pad_sel;
  logic [7:0]      buf_rd, src_byte, xf_byte, next_byte;

  // ---------------- input side ----------------
  assign slot_free = !out_valid_q || out_ready;

  always_comb begin
    unique case (phase_q)
      ST_IDLE, ST_FILL: in_ready = 1'b1;
      ST_FLOW:          in_ready = slot_free;
      default:          in_ready = 1'b0;
    endcase
  end

  assign in_fire    = in_valid && in_ready;
  assign fill_beat  = in_fire && ((phase_q == ST_IDLE && in_sof) || phase_q == ST_FILL);
  assign fill_idx   = (phase_q == ST_IDLE) ? '0 : cnt_q;
  assign fill_last  = in_eof || (fill_idx == LAST_IDX);
  assign base_eff   = (phase_q == ST_IDLE) ? in_base_zero : base_q;
  assign keep_order = base_eff && hit_next && (fill_idx == LAST_IDX);

  cfgbo_hdr_match #(
    .HDR_FILL (HDR_FILL),
    .SYNC_WORD(SYNC_WORD),
    .IDXW     (CNTW)
  ) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (fill_beat),
    .first   (phase_q == ST_IDLE),
    .idx     (fill_idx),
    .data    (in_data),
    .hit_next(hit_next)
  );

  cfgbo_prefix_buf #(
    .DEPTH(PAGE_BYTES),
    .W    (8)
  ) u_prefix (
    .clk    (clk),
    .wr_en  (fill_beat),
    .wr_idx (fill_idx[IDXW-1:0]),
    .wr_data(in_data),
    .rd_idx (rd_q[IDXW-1:0]),
    .rd_data(buf_rd)
  );

  // ---------------- output side ----------------
  assign drain_last = (rd_q == cnt_q - 1'b1);

  always_comb begin
    emit    = 1'b0;
    img_end = 1'b0;
    pad_sel = 1'b0;
    unique case (phase_q)
      ST_DRAIN: begin
        emit    = slot_free;
        img_end = eof_q && (cnt_q == FULL_CNT) && drain_last;
      end
      ST_FLOW: begin
        emit    = in_fire;
        img_end = in_eof && (pos_q == POS_LAST);
      end
      ST_PAD: begin
        emit    = slot_free;
        pad_sel = 1'b1;
        img_end = (pos_q == POS_LAST);
      end
      default: ;
    endcase
  end

  assign src_byte = (phase_q == ST_DRAIN) ? buf_rd : in_data;

  cfgbo_lane_xform #(.W(8)) u_xform (
    .rev  (rev_q),
    .in_b (src_byte),
    .out_b(xf_byte)
  );

  assign next_byte = pad_sel ? 8'hFF : xf_byte;

  // ---------------- phase sequencing ----------------
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      ST_IDLE, ST_FILL:
        if (fill_beat) phase_d = fill_last ? ST_DRAIN : ST_FILL;
      ST_DRAIN:
        if (emit && drain_last)
          phase_d = !eof_q ? ST_FLOW : ((cnt_q == FULL_CNT) ? ST_IDLE : ST_PAD);
      ST_FLOW:
        if (emit && in_eof) phase_d = (pos_q == POS_LAST) ? ST_IDLE : ST_PAD;
      ST_PAD:
        if (emit && pos_q == POS_LAST) phase_d = ST_IDLE;
      default: phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= ST_IDLE;
      cnt_q       <= '0;
      rd_q        <= '0;
      pos_q       <= '0;
      rev_q       <= 1'b1;
      eof_q       <= 1'b0;
      base_q      <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= 8'h00;
      pe_q        <= 1'b0;
      ie_q        <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (fill_beat) begin
        cnt_q <= fill_idx + 1'b1;
        if (phase_q == ST_IDLE) begin
          base_q <= in_base_zero;
          pos_q  <= '0;
        end
        if (fill_last) begin
          rev_q <= !keep_order;
          eof_q <= in_eof;
          rd_q  <= '0;
        end
      end
      if (emit) begin
        pos_q       <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
        out_valid_q <= 1'b1;
        out_data_q  <= next_byte;
        pe_q        <= (pos_q == POS_LAST);
        ie_q        <= img_end;
        if (phase_q == ST_DRAIN) rd_q <= rd_q + 1'b1;
      end else if (out_ready) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid    = out_valid_q;
  assign out_data     = out_data_q;
  assign out_page_end = pe_q;
  assign out_img_end  = ie_q;

  // ---------------- assertions ----------------
  p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_page_end) && $stable(out_img_end)));

  p_img_on_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_img_end) |-> out_page_end);

  p_mode_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_FLOW || phase_q == ST_PAD) |=> $stable(rev_q));

  p_pad_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_PAD && slot_free) |=> (out_valid && out_data == 8'hFF));

  p_quiet_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_FILL) |=> !$rose(out_valid));

endmodule

// File: tb/tb_cfg_bitorder_pager.sv
module tb_cfg_bitorder_pager;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE = 32;
  localparam int WATCHDOG = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_sof, in_eof, in_base_zero;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_page_end, out_img_end;
  logic [7:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_bitorder_pager dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_base_zero(in_base_zero),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_page_end(out_page_end), .out_img_end(out_img_end)
  );

  typedef struct { logic [7:0] d; logic sof; logic eof; logic base; } beat_t;
  typedef struct { logic [7:0] d; logic pe; logic ie; string tag; } exp_t;

  beat_t      bq[$];
  exp_t       eq[$];
  logic [7:0] img[$];
  int         checks = 0;
  int         errors = 0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [7:0] mirror(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [7:0] sig_byte(input int i);
    logic [7:0] tail [4] = '{8'h55, 8'h99, 8'hAA, 8'h66};
    return (i < 16) ? 8'hFF : tail[i-16];
  endfunction

  task automatic next_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  // build an image in img: optional signature with one corrupted position, then payload
  task automatic make_img(input int len, input bit with_sig, input int bad_pos, input int seed);
    img.delete();
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'((i * 37 + seed * 11 + 5) & 255);
      if (with_sig && i < 20) b = sig_byte(i);
      if (i == bad_pos) b = b ^ 8'h10;
      img.push_back(b);
    end
  endtask

  // reference model: decision, mapping, padding and flags from the requirements
  task automatic add_image(input logic base, input string tag);
    int  len, total;
    bit  keep;
    len  = img.size();
    keep = base && (len >= PAGE);
    for (int i = 0; i < 20 && i < len; i++) if (img[i] != sig_byte(i)) keep = 0;
    for (int i = 0; i < len; i++) begin
      beat_t bt;
      bt.d = img[i]; bt.sof = (i == 0); bt.eof = (i == len - 1); bt.base = base;
      bq.push_back(bt);
    end
    total = ((len + PAGE - 1) / PAGE) * PAGE;
    for (int k = 0; k < total; k++) begin
      exp_t e;
      if (k < len) begin
        e.d = keep ? img[k] : mirror(img[k]);
        e.tag = tag;
      end else begin
        e.d = 8'hFF;
        e.tag = "R6";
      end
      e.pe = ((k % PAGE) == PAGE - 1);
      e.ie = (k == total - 1);
      eq.push_back(e);
    end
  endtask

  task automatic add_junk(input int n);
    for (int i = 0; i < n; i++) begin
      beat_t bt;
      bt.d = 8'(8'hC3 + i); bt.sof = 1'b0; bt.eof = 1'b0; bt.base = 1'b1;
      bq.push_back(bt);
    end
  endtask

  initial begin
    int   bi, cycles, idle;
    bit   in_pend, out_pend, stall_prev;
    logic [7:0] pd, sd;
    logic ppe, pie, spe, sie;

    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_sof = 1'b0; in_eof = 1'b0;
    in_base_zero = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R7 reset: out_valid actual %b expected 0", out_valid);
    end
    rst_n = 1'b1;

    // R10: the sequence mixes kept and mirrored images back to back
    make_img(40, 1, -1, 1); add_image(1'b1, "R1 R7");
    make_img(50, 1, 18, 2); add_image(1'b1, "R2 R10");
    make_img(32, 1, -1, 3); add_image(1'b1, "R1 exact page");
    add_junk(3);                                    // R9
    make_img(25, 1, -1, 4); add_image(1'b1, "R3");
    make_img(40, 1, -1, 5); add_image(1'b0, "R4");
    add_junk(2);                                    // R9
    make_img(1, 0, -1, 6);  add_image(1'b1, "R3 R6 single byte");
    make_img(70, 1, 0, 7);  add_image(1'b1, "R2 R7");
    make_img(33, 1, -1, 8); add_image(1'b1, "R1 R10");

    bi = 0; cycles = 0; idle = 0;
    in_pend = 0; out_pend = 0; stall_prev = 0;
    pd = 0; sd = 0; ppe = 0; pie = 0; spe = 0; sie = 0;
    while (cycles < WATCHDOG && idle < 40) begin
      @(negedge clk);
      // outcome of the edge just passed
      if (in_pend) bi++;
      if (out_pend) begin
        if (eq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 unexpected output: actual %h expected none", pd);
        end else begin
          exp_t e;
          e = eq.pop_front();
          checks++;
          if (pd !== e.d) begin
            errors++;
            $display("FAIL %s data: actual %h expected %h", e.tag, pd, e.d);
          end
          checks++;
          if (ppe !== e.pe || pie !== e.ie) begin
            errors++;
            $display("FAIL R5 flags: actual page_end %b img_end %b expected %b %b",
                     ppe, pie, e.pe, e.ie);
          end
        end
      end
      if (stall_prev) begin
        checks++;
        if (!(out_valid === 1'b1 && out_data === sd && out_page_end === spe && out_img_end === sie)) begin
          errors++;
          $display("FAIL R8 hold: actual v%b %h %b %b expected v1 %h %b %b",
                   out_valid, out_data, out_page_end, out_img_end, sd, spe, sie);
        end
      end
      // drive the next cycle
      next_rng();
      if (!(in_valid && !in_pend)) begin
        if (bi < bq.size() && rng[1:0] != 2'b00) begin
          in_valid = 1'b1; in_data = bq[bi].d; in_sof = bq[bi].sof;
          in_eof = bq[bi].eof; in_base_zero = bq[bi].base;
        end else begin
          in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        end
      end
      out_ready = (rng[5:4] != 2'b00);
      #1;
      in_pend    = in_valid && in_ready;
      out_pend   = out_valid && out_ready;
      pd = out_data; ppe = out_page_end; pie = out_img_end;
      stall_prev = out_valid && !out_ready;
      sd = out_data; spe = out_page_end; sie = out_img_end;
      cycles++;
      if (bi >= bq.size() && eq.size() == 0 && !in_valid) idle++;
    end

    if (cycles >= WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    checks++;
    if (eq.size() != 0) begin
      errors++;
      $display("FAIL R5 count: actual %0d bytes missing expected 0", eq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule